// File: doc/BRIEF.md
# Multiplexed Pixel Input Demultiplexer

This block sits at the digital pixel input of a video encoder. It samples a 16-bit pixel bus on a pixel clock and rebuilds complete pixels from one, two, three or four bus words, depending on a 4-bit format code. Each rebuilt pixel leaves on a one-cycle strobe as three 8-bit components. For RGB the components are R, G and B, and 5-bit and 6-bit fields are widened by copying their top bits into the freed low bits. For YCrCb the components are Y, Cb and Cr, and every Y sample is paired with the chroma pair it shares.

The supported packings are these. Non-multiplexed 16-bit and 15-bit RGB words. Non-multiplexed 16-bit YCrCb words. Byte streams that carry two bytes per pixel for 5-6-5 or 5-5-5 RGB. A byte stream that carries three bytes per pixel for 24-bit RGB. Two 12-bit words per 24-bit RGB pixel. Two 16-bit words per 24-bit RGB pixel, where the second word holds a spare byte. A byte stream in Cb, Y, Cr, Y order.

When the pixel clock runs at the pixel rate, a multiplexed format can take one word on each clock edge. A line-start input realigns the word phase at the first active word of every line.

Top module: `pix_demux`

## Requirements
- R1: Format codes 7 and 10 to 15 are reserved. One clock after a reserved code is applied, `fmt_err_o` reads 1, and no pixel strobe is given while it is 1. Out of reset, and one clock after a valid code, `fmt_err_o` and `pix_vld_o` read 0.
- R2: Code 0 (16-bit RGB, one word per pixel) takes R from bits 15:11, G from 10:5 and B from 4:0. A 5-bit value v becomes {v, v[4:2]} and a 6-bit value becomes {v, v[5:4]}.
- R3: Code 1 (15-bit RGB, one word per pixel) takes R from bits 14:10, G from 9:5 and B from 4:0, widens each as 5-bit, and ignores bit 15.
- R4: Code 3 (16-bit YCrCb) carries Y in bits 15:8 and chroma in bits 7:0. The first word of a pair holds Cb and the second holds Cr. Two pixels are produced, (Y0, Cb, Cr) and then (Y1, Cb, Cr), one clock apart. `ycc_o` is 1 for both.
- R5: Codes 2 (5-5-5) and 4 (5-6-5) take two bytes on bits 7:0. The first byte is the low half of the 16-bit RGB word and the second is the high half. Bits 15:8 are ignored.
- R6: Code 6 takes three bytes on bits 7:0 in the order B, G, R.
- R7: Code 5 takes two 12-bit words on bits 11:0. The first word is {G[3:0], B[7:0]} and the second is {R[7:0], G[7:4]}. Bits 15:12 are ignored.
- R8: Code 8 takes two 16-bit words. The first word is {G, B} and the second is {spare, R}, with R in bits 7:0 and the spare byte ignored.
- R9: Code 9 takes bytes on bits 7:0 in the order Cb, Y0, Cr, Y1. It produces (Y0, Cb, Cr) and then (Y1, Cb, Cr), one clock apart.
- R10: With `dual_edge_i` at 1 and a multiplexed code (2, 4, 5, 8 or 9), each clock takes two words. The word held at the falling edge comes first and the word at the rising edge comes second. For codes 0, 1, 3 and 6, `dual_edge_i` has no effect and only the rising-edge word is used.
- R11: A word that arrives with `sol_i` at 1 is always the first word of a pixel group. Any partial group is dropped.
- R12: A pixel's strobe is seen one clock after the rising edge that captured its last word. Clocks with `vld_i` at 0 neither add words nor advance the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmt_i | input | 4 | Input format code |
| dual_edge_i | input | 1 | Capture on both clock edges for multiplexed codes |
| vld_i | input | 1 | Bus words are valid at this rising edge |
| sol_i | input | 1 | First active word of a line |
| data_i | input | 16 | Pixel data bus |
| pix_vld_o | output | 1 | Pixel strobe |
| ycc_o | output | 1 | Pixel is YCrCb (1) or RGB (0) |
| comp0_o | output | 8 | R or Y |
| comp1_o | output | 8 | G or Cb |
| comp2_o | output | 8 | B or Cr |
| fmt_err_o | output | 1 | Reserved format code selected |

## Verification
The bench fills the unused high bus bits with nonzero values in the byte and 12-bit modes, and fills the spare byte in the 32-bit mode. A design that leaks those bits into a component returns wrong colour values.

Each YCrCb check expects the second Y one clock after the first, carrying the same chroma pair. A design that drops or mis-times the held pixel, or pairs a Y with the wrong chroma, gives a missing, early or wrong pixel.

Dual-edge runs check both the order of the two words and that one pixel is produced per clock. A separate run checks that dual-edge has no effect in a non-multiplexed mode, where a design that mixes in the falling-edge word would corrupt the pixel.

A lone byte followed by a line start would pair with the wrong byte if the phase were not reset. Idle clocks inside a pair, and a reserved code, would give extra or missing strobes if the design mishandled them.

// File: rtl/pix_demux_pkg.sv
package pix_demux_pkg;
  localparam int DATA_W = 16;
  localparam int COMP_W = 8;
  localparam int MAX_GRP = 4;

  localparam logic [3:0] FMT_RGB565  = 4'd0;
  localparam logic [3:0] FMT_RGB555  = 4'd1;
  localparam logic [3:0] FMT_B2_555  = 4'd2;
  localparam logic [3:0] FMT_YC16    = 4'd3;
  localparam logic [3:0] FMT_B2_565  = 4'd4;
  localparam logic [3:0] FMT_W12X2   = 4'd5;
  localparam logic [3:0] FMT_B3_888  = 4'd6;
  localparam logic [3:0] FMT_W16X2   = 4'd8;
  localparam logic [3:0] FMT_YC8     = 4'd9;

  // words per group; 0 marks a reserved code
  function automatic logic [2:0] grp_size(input logic [3:0] f);
    case (f)
      FMT_RGB565, FMT_RGB555:                      grp_size = 3'd1;
      FMT_YC16, FMT_B2_555, FMT_B2_565,
      FMT_W12X2, FMT_W16X2:                        grp_size = 3'd2;
      FMT_B3_888:                                  grp_size = 3'd3;
      FMT_YC8:                                     grp_size = 3'd4;
      default:                                     grp_size = 3'd0;
    endcase
  endfunction

  function automatic logic dual_ok(input logic [3:0] f);
    dual_ok = (f == FMT_B2_555) || (f == FMT_B2_565) || (f == FMT_W12X2) ||
              (f == FMT_W16X2)  || (f == FMT_YC8);
  endfunction

  function automatic logic is_ycc(input logic [3:0] f);
    is_ycc = (f == FMT_YC16) || (f == FMT_YC8);
  endfunction

  function automatic logic [COMP_W-1:0] widen5(input logic [4:0] v);
    widen5 = {v, v[4:2]};
  endfunction

  function automatic logic [COMP_W-1:0] widen6(input logic [5:0] v);
    widen6 = {v, v[5:4]};
  endfunction
endpackage

// File: rtl/pix_capture.sv
module pix_capture
  import pix_demux_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] fall_q_o
);
  // falling-edge half of dual-edge capture
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fall_q_o <= '0;
    else         fall_q_o <= data_i;
  end
endmodule

// File: rtl/pix_unpack.sv
module pix_unpack
  import pix_demux_pkg::*;
(
  input  logic [3:0]        fmt_i,
  input  logic [DATA_W-1:0] s0_i,
  input  logic [DATA_W-1:0] s1_i,
  input  logic [DATA_W-1:0] s2_i,
  input  logic [DATA_W-1:0] s3_i,
  output logic [COMP_W-1:0] p0_o,
  output logic [COMP_W-1:0] p1_o,
  output logic [COMP_W-1:0] p2_o,
  output logic [COMP_W-1:0] y1_o
);
  logic [DATA_W-1:0] bw;

  always_comb begin
    bw   = {s1_i[7:0], s0_i[7:0]};
    p0_o = '0;
    p1_o = '0;
    p2_o = '0;
    y1_o = '0;
    case (fmt_i)
      FMT_RGB565: begin
        p0_o = widen5(s0_i[15:11]); p1_o = widen6(s0_i[10:5]); p2_o = widen5(s0_i[4:0]);
      end
      FMT_RGB555: begin
        p0_o = widen5(s0_i[14:10]); p1_o = widen5(s0_i[9:5]); p2_o = widen5(s0_i[4:0]);
      end
      FMT_B2_565: begin
        p0_o = widen5(bw[15:11]); p1_o = widen6(bw[10:5]); p2_o = widen5(bw[4:0]);
      end
      FMT_B2_555: begin
        p0_o = widen5(bw[14:10]); p1_o = widen5(bw[9:5]); p2_o = widen5(bw[4:0]);
      end
      FMT_YC16: begin
        p0_o = s0_i[15:8]; p1_o = s0_i[7:0]; p2_o = s1_i[7:0]; y1_o = s1_i[15:8];
      end
      FMT_W12X2: begin
        p0_o = s1_i[11:4]; p1_o = {s1_i[3:0], s0_i[11:8]}; p2_o = s0_i[7:0];
      end
      FMT_B3_888: begin
        p0_o = s2_i[7:0]; p1_o = s1_i[7:0]; p2_o = s0_i[7:0];
      end
      FMT_W16X2: begin
        p0_o = s1_i[7:0]; p1_o = s0_i[15:8]; p2_o = s0_i[7:0];
      end
      FMT_YC8: begin
        p1_o = s0_i[7:0]; p0_o = s1_i[7:0]; p2_o = s2_i[7:0]; y1_o = s3_i[7:0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pix_seq.sv
module pix_seq
  import pix_demux_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        fmt_i,
  input  logic              dual_i,
  input  logic              vld_i,
  input  logic              sol_i,
  input  logic [DATA_W-1:0] w_fall_i,
  input  logic [DATA_W-1:0] w_rise_i,
  output logic              vld_o,
  output logic              ycc_o,
  output logic [COMP_W-1:0] c0_o,
  output logic [COMP_W-1:0] c1_o,
  output logic [COMP_W-1:0] c2_o,
  output logic              err_o
);
  localparam int PH_W = $clog2(MAX_GRP);

  logic [PH_W-1:0]   ph_q, ph_eff;
  logic [2:0]        g, cnt, sum;
  logic              err, two, done, take;
  logic [DATA_W-1:0] w0;
  logic [DATA_W-1:0] hold_q [MAX_GRP];
  logic [DATA_W-1:0] slot   [MAX_GRP];
  logic [COMP_W-1:0] p0, p1, p2, y1;
  logic              pend_q;
  logic [COMP_W-1:0] pend_y_q;

  always_comb begin
    g      = grp_size(fmt_i);
    err    = (g == 3'd0);
    two    = dual_i && dual_ok(fmt_i);
    ph_eff = sol_i ? '0 : ph_q;
    cnt    = two ? 3'd2 : 3'd1;
    sum    = {1'b0, ph_eff} + cnt;
    take   = vld_i && !err;
    done   = take && (sum >= g);
    w0     = two ? w_fall_i : w_rise_i;
    for (int i = 0; i < MAX_GRP; i++) begin
      if (i < int'(ph_eff))       slot[i] = hold_q[i];
      else if (i == int'(ph_eff)) slot[i] = w0;
      else                        slot[i] = w_rise_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MAX_GRP; i++) hold_q[i] <= '0;
      ph_q <= '0;
    end else if (take) begin
      for (int i = 0; i < MAX_GRP; i++) begin
        if (i == int'(ph_eff))                  hold_q[i] <= w0;
        else if (two && i == int'(ph_eff) + 1)  hold_q[i] <= w_rise_i;
      end
      ph_q <= done ? '0 : sum[PH_W-1:0];
    end
  end

  pix_unpack u_unpack (
    .fmt_i (fmt_i),
    .s0_i  (slot[0]),
    .s1_i  (slot[1]),
    .s2_i  (slot[2]),
    .s3_i  (slot[3]),
    .p0_o  (p0),
    .p1_o  (p1),
    .p2_o  (p2),
    .y1_o  (y1)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o    <= 1'b0;
      ycc_o    <= 1'b0;
      c0_o     <= '0;
      c1_o     <= '0;
      c2_o     <= '0;
      err_o    <= 1'b0;
      pend_q   <= 1'b0;
      pend_y_q <= '0;
    end else begin
      err_o <= err;
      if (done) begin
        vld_o    <= 1'b1;
        ycc_o    <= is_ycc(fmt_i);
        c0_o     <= p0;
        c1_o     <= p1;
        c2_o     <= p2;
        pend_q   <= is_ycc(fmt_i);
        pend_y_q <= y1;
      end else if (pend_q && !err) begin
        // second Y reuses the held chroma pair
        vld_o  <= 1'b1;
        c0_o   <= pend_y_q;
        pend_q <= 1'b0;
      end else begin
        vld_o  <= 1'b0;
        pend_q <= 1'b0;
      end
    end
  end

  // R1
  fmt_err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !vld_o);

  // R4
  pend_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> (vld_o && ycc_o));

  // R10
  dual_rate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && two && g == 3'd2) |=> vld_o);

  // R11
  sol_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && sol_i && !two && g > 3'd1) |=> (ph_q == PH_W'(1)));
endmodule

// File: rtl/pix_demux.sv
module pix_demux
  import pix_demux_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        fmt_i,
  input  logic              dual_edge_i,
  input  logic              vld_i,
  input  logic              sol_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              pix_vld_o,
  output logic              ycc_o,
  output logic [COMP_W-1:0] comp0_o,
  output logic [COMP_W-1:0] comp1_o,
  output logic [COMP_W-1:0] comp2_o,
  output logic              fmt_err_o
);
  logic [DATA_W-1:0] fall_q;

  pix_capture u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .data_i   (data_i),
    .fall_q_o (fall_q)
  );

  pix_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fmt_i    (fmt_i),
    .dual_i   (dual_edge_i),
    .vld_i    (vld_i),
    .sol_i    (sol_i),
    .w_fall_i (fall_q),
    .w_rise_i (data_i),
    .vld_o    (pix_vld_o),
    .ycc_o    (ycc_o),
    .c0_o     (comp0_o),
    .c1_o     (comp1_o),
    .c2_o     (comp2_o),
    .err_o    (fmt_err_o)
  );
endmodule

// File: tb/pix_demux_tb_top.sv
module pix_demux_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic [3:0]  fmt;
  logic        dual, vld, sol;
  logic [15:0] data;
  logic        pix_vld, ycc, ferr;
  logic [7:0]  c0, c1, c2;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  typedef struct {
    string      req;
    logic       y;
    logic [7:0] a, b, c;
    int         at;
  } px_t;
  px_t exp_q[$];

  pix_demux dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fmt_i(fmt), .dual_edge_i(dual), .vld_i(vld),
    .sol_i(sol), .data_i(data), .pix_vld_o(pix_vld), .ycc_o(ycc),
    .comp0_o(c0), .comp1_o(c1), .comp2_o(c2), .fmt_err_o(ferr)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] x5(input logic [4:0] v); return {v, v[4:2]}; endfunction
  function automatic logic [7:0] x6(input logic [5:0] v); return {v, v[5:4]}; endfunction

  // monitor: pops expected pixels as strobes appear
  always @(posedge clk) begin
    #1;
    if (rst_n && pix_vld) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL unexpected strobe: got y=%0b %h %h %h, expected none (R1/R11)", ycc, c0, c1, c2);
      end else begin
        px_t e;
        e = exp_q.pop_front();
        if (ycc !== e.y || c0 !== e.a || c1 !== e.b || c2 !== e.c) begin
          bad++;
          $display("FAIL %s: got y=%0b %h %h %h, expected y=%0b %h %h %h",
                   e.req, ycc, c0, c1, c2, e.y, e.a, e.b, e.c);
        end
        if (cyc != e.at) begin
          bad++;
          $display("FAIL %s/R12 latency: got cycle %0d, expected %0d", e.req, cyc, e.at);
        end
      end
    end
  end

  task automatic step(input logic [15:0] a, input logic [15:0] b, input logic v, input logic s);
    @(posedge clk);
    #2 data = a; vld = v; sol = s;
    #5 data = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(16'h0, 16'h0, 1'b0, 1'b0);
  endtask

  task automatic set_fmt(input logic [3:0] f, input logic d);
    @(posedge clk);
    #2 fmt = f; dual = d; vld = 1'b0; sol = 1'b0;
  endtask

  // expected pixel, visible dly cycles after the current cycle
  task automatic expect_px(input string r, input logic y, input logic [7:0] a,
                           input logic [7:0] b, input logic [7:0] c, input int dly);
    px_t e;
    e.req = r; e.y = y; e.a = a; e.b = b; e.c = c; e.at = cyc + dly;
    exp_q.push_back(e);
  endtask

  task automatic chk(input string r, input logic [31:0] got, input logic [31:0] want);
    total++;
    if (got !== want) begin
      bad++;
      $display("FAIL %s: got %h, expected %h", r, got, want);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fmt = 4'd0; dual = 1'b0; vld = 1'b0; sol = 1'b0; data = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    #3;
    chk("R1 reset strobe", {31'd0, pix_vld}, 32'd0);
    chk("R1 reset err", {31'd0, ferr}, 32'd0);

    // R2: code 0
    set_fmt(4'd0, 1'b0);
    step(16'hA5A5, {5'h1B, 6'h2C, 5'h07}, 1, 1); expect_px("R2", 0, x5(5'h1B), x6(6'h2C), x5(5'h07), 1);
    step(16'hA5A5, 16'hFFFF, 1, 0);              expect_px("R2", 0, 8'hFF, 8'hFF, 8'hFF, 1);
    step(16'hA5A5, 16'h0000, 1, 0);              expect_px("R2", 0, 8'h00, 8'h00, 8'h00, 1);
    idle(2);

    // R3: code 1, bit 15 ignored
    set_fmt(4'd1, 1'b0);
    step(16'h0, {1'b1, 5'h12, 5'h0D, 5'h19}, 1, 1); expect_px("R3", 0, x5(5'h12), x5(5'h0D), x5(5'h19), 1);
    idle(2);

    // R4: code 3, pair of Y sharing chroma
    set_fmt(4'd3, 1'b0);
    step(16'h0, {8'h40, 8'h80}, 1, 1);
    step(16'h0, {8'h50, 8'h90}, 1, 0);
    expect_px("R4", 1, 8'h40, 8'h80, 8'h90, 1);
    expect_px("R4", 1, 8'h50, 8'h80, 8'h90, 2);
    idle(3);

    // R5: codes 2 and 4, high bus byte carries junk
    set_fmt(4'd2, 1'b0);
    step(16'h0, {8'hC3, 8'b101_01101}, 1, 1);
    step(16'h0, {8'h3C, 8'b0_10110_10}, 1, 0);
    expect_px("R5", 0, x5(5'h16), x5(5'h15), x5(5'h0D), 1);
    idle(2);
    set_fmt(4'd4, 1'b0);
    step(16'h0, {8'hEE, 8'h34}, 1, 1);
    step(16'h0, {8'h77, 8'h9A}, 1, 0);
    expect_px("R5", 0, x5(5'h13), x6(6'h11), x5(5'h14), 1);
    idle(2);

    // R6: code 6, B G R
    set_fmt(4'd6, 1'b0);
    step(16'h0, 16'hF011, 1, 1);
    step(16'h0, 16'h0F22, 1, 0);
    step(16'h0, 16'hAA33, 1, 0);
    expect_px("R6", 0, 8'h33, 8'h22, 8'h11, 1);
    idle(2);

    // R7: code 5, 12-bit words, top nibble junk
    set_fmt(4'd5, 1'b0);
    step(16'h0, 16'hF_6_5B, 1, 1);
    step(16'h0, 16'hE_C3_A, 1, 0);
    expect_px("R7", 0, 8'hC3, 8'hA6, 8'h5B, 1);
    idle(2);

    // R8: code 8, spare byte junk; R12 idle clock inside the pair
    set_fmt(4'd8, 1'b0);
    step(16'h0, 16'h7E19, 1, 1);
    step(16'h0, 16'h5555, 0, 0);
    step(16'h0, 16'hD2C4, 1, 0);
    expect_px("R8", 0, 8'hC4, 8'h7E, 8'h19, 1);
    idle(2);

    // R9: code 9, single edge
    set_fmt(4'd9, 1'b0);
    step(16'h0, 16'hFF60, 1, 1);
    step(16'h0, 16'hFF21, 1, 0);
    step(16'h0, 16'hFFA0, 1, 0);
    step(16'h0, 16'hFF22, 1, 0);
    expect_px("R9", 1, 8'h21, 8'h60, 8'hA0, 1);
    expect_px("R9", 1, 8'h22, 8'h60, 8'hA0, 2);
    idle(3);

    // R10: dual edge, code 4, falling word first
    set_fmt(4'd4, 1'b1);
    step(16'h0034, 16'h009A, 1, 1); expect_px("R10", 0, x5(5'h13), x6(6'h11), x5(5'h14), 1);
    step(16'h00FF, 16'h0000, 1, 0); expect_px("R10", 0, 8'h00, x6(6'h07), 8'hFF, 1);
    idle(2);
    // R10: dual edge, code 9
    set_fmt(4'd9, 1'b1);
    step(16'h0011, 16'h0077, 1, 1);
    step(16'h0022, 16'h0088, 1, 0);
    expect_px("R10", 1, 8'h77, 8'h11, 8'h22, 1);
    expect_px("R10", 1, 8'h88, 8'h11, 8'h22, 2);
    idle(3);
    // R10: dual edge has no effect on code 0
    set_fmt(4'd0, 1'b1);
    step(16'hFFFF, {5'h03, 6'h21, 5'h1E}, 1, 1); expect_px("R10", 0, x5(5'h03), x6(6'h21), x5(5'h1E), 1);
    idle(2);

    // R11: lone byte dropped at line start
    set_fmt(4'd2, 1'b0);
    step(16'h0, 16'h0011, 1, 1);
    step(16'h0, 16'h00FF, 1, 1);
    step(16'h0, 16'h0000, 1, 0);
    expect_px("R11", 0, 8'h00, x5(5'h07), 8'hFF, 1);
    idle(2);

    // R1: reserved codes
    set_fmt(4'd12, 1'b0);
    step(16'h0, 16'h1234, 1, 1);
    chk("R1 err code 12", {31'd0, ferr}, 32'd1);
    step(16'h0, 16'h5678, 1, 0);
    set_fmt(4'd7, 1'b0);
    step(16'h0, 16'h9ABC, 1, 1);
    chk("R1 err code 7", {31'd0, ferr}, 32'd1);
    idle(2);
    set_fmt(4'd0, 1'b0);
    step(16'h0, 16'h0, 0, 0);
    chk("R1 err cleared", {31'd0, ferr}, 32'd0);
    idle(3);

    chk("R12 all expected pixels seen", exp_q.size(), 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule